// File: doc/BRIEF.md
# Warp Issue Sequencer

This block schedules 32-thread warps onto an 8-lane execution array. It keeps a pool of up to 24 resident warps. On each instruction boundary it picks the next ready one in round-robin order. It then streams that warp's instruction to the lanes as four consecutive beats, one lane group of eight threads per beat. When a new warp is available at the boundary, its first beat follows the previous warp's last beat directly, with no idle cycle.

Each warp carries a 32-bit active-thread mask and a four-entry reconvergence stack. A control port reports three kinds of event for a named warp: a branch outcome, arrival at a reconvergence point, or warp exit. On a divergent branch the taken threads run first. The not-taken threads run after the first reconvergence event. The full mask returns after the second. The lane enables for each beat come from the mask as it stood when that instruction started.

Top module: `warp_issue_seq`

## Requirements
- R1: After reset no instruction is issued (`issue_valid` 0, `lane_en` 0) and no warp is resident.
- R2: An issued instruction occupies four consecutive cycles with `lane_grp` 0,1,2,3 and a constant `issue_wid`. In group g, `lane_en` equals active-mask bits [8g+7:8g].
- R3: At an instruction boundary the warp chosen is the first one that is both ready and resident, searching upward with wrap-around from the warp issued last. After reset the search starts at warp 0.
- R4: When a candidate exists at a boundary, its group 0 follows the previous group 3 in the next cycle. With no candidate, `issue_valid` and `lane_en` are 0.
- R5: A warp that was never launched, or has left through `ctl_op` 3 (exit), is never issued, even while its ready bit is high.
- R6: Launching a warp makes it resident, sets its mask to all ones and empties its stack. A launch overrides any control event for the same warp in the same cycle.
- R7: `ctl_op` 1 (branch) with t = `ctl_taken` & mask is divergent when t is neither 0 nor the mask. A divergent branch sets the mask to t and pushes an entry holding the not-taken bits, the prior mask and `ctl_rpc`. At group 0, `issue_rpc` shows the top entry's point, or 0 when the stack is empty.
- R8: A non-divergent branch leaves the mask and the stack unchanged.
- R9: `ctl_op` 2 (reconverge) acts on the top entry. The first time, it switches the mask to the not-taken bits. The second time, it restores the prior mask and removes the entry. With an empty stack it has no effect.
- R10: A divergent branch arriving while the warp already holds 4 entries is ignored.
- R11: A lane group whose mask bits are all zero still takes its beat, with `lane_en` 0.
- R12: Control events that land while a warp's instruction is in flight do not alter that instruction's remaining beats. They apply from that warp's next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ready | input | NWARP | Per-warp readiness |
| launch | input | 1 | Launch warp `launch_wid` |
| launch_wid | input | WIDW | Warp being launched |
| ctl_op | input | 2 | 0 none, 1 branch, 2 reconverge, 3 exit |
| ctl_wid | input | WIDW | Warp the control event refers to |
| ctl_taken | input | 32 | Branch outcome per thread |
| ctl_rpc | input | PCW | Reconvergence point for a branch |
| issue_valid | output | 1 | A beat is being issued |
| issue_wid | output | WIDW | Warp being issued |
| lane_grp | output | 2 | Lane group index of this beat |
| lane_en | output | 8 | Per-lane enable |
| issue_rpc | output | PCW | Top reconvergence point of the issuing warp |

## Verification
Two things can meet in one cycle: a control event for a warp, and that warp's own instruction being in flight or being selected. The bench raises a branch on the issuing warp during its group 1. It expects groups 2 and 3 to keep the old enables, and the following instruction to use the taken mask. A second collision comes from a launch and a reconverge aimed at the same warp in one cycle. For that case the bench expects the full mask and an empty stack.

// File: rtl/warp_issue_seq.sv
module warp_issue_seq #(
  parameter int NWARP = 24,
  parameter int WARP_THREADS = 32,
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  parameter int PCW = 8,
  localparam int WIDW = $clog2(NWARP),
  localparam int GRPS = WARP_THREADS / LANES,
  localparam int GW = $clog2(GRPS),
  localparam int SPW = $clog2(DEPTH + 1),
  localparam int SW = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NWARP-1:0]        ready,
  input  logic                    launch,
  input  logic [WIDW-1:0]         launch_wid,
  input  logic [1:0]              ctl_op,
  input  logic [WIDW-1:0]         ctl_wid,
  input  logic [WARP_THREADS-1:0] ctl_taken,
  input  logic [PCW-1:0]          ctl_rpc,
  output logic                    issue_valid,
  output logic [WIDW-1:0]         issue_wid,
  output logic [GW-1:0]           lane_grp,
  output logic [LANES-1:0]        lane_en,
  output logic [PCW-1:0]          issue_rpc
);
  localparam logic [1:0] OP_BR = 2'd1, OP_RECONV = 2'd2, OP_EXIT = 2'd3;

  logic [NWARP-1:0]        resident;
  logic [WARP_THREADS-1:0] amask  [NWARP];
  logic [SPW-1:0]          sp     [NWARP];
  logic [WARP_THREADS-1:0] st_nt  [NWARP][DEPTH];
  logic [WARP_THREADS-1:0] st_org [NWARP][DEPTH];
  logic [PCW-1:0]          st_rpc [NWARP][DEPTH];
  logic                    st_ph  [NWARP][DEPTH];
  logic [WARP_THREADS-1:0] cur_mask;
  logic [WIDW-1:0]         last, sel;
  logic                    found;
  logic [NWARP-1:0]        cand;

  assign cand = ready & resident;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = 1; i <= NWARP; i++) begin
      int idx;
      idx = (int'(last) + i) % NWARP;
      if (!found && cand[idx]) begin
        found = 1'b1;
        sel   = WIDW'(idx);
      end
    end
  end

  wire [WARP_THREADS-1:0] cm   = amask[ctl_wid];
  wire [WARP_THREADS-1:0] tk   = ctl_taken & cm;
  wire [SPW-1:0]          csp  = sp[ctl_wid];
  wire [SW-1:0]           ctop = SW'(csp - 1'b1);
  wire                    ctl_go = (ctl_op != 2'd0) && (int'(ctl_wid) < NWARP) &&
                                   !(launch && launch_wid == ctl_wid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resident <= '0;
      for (int w = 0; w < NWARP; w++) begin
        amask[w] <= '1;
        sp[w]    <= '0;
        for (int d = 0; d < DEPTH; d++) begin
          st_nt[w][d]  <= '0;
          st_org[w][d] <= '0;
          st_rpc[w][d] <= '0;
          st_ph[w][d]  <= 1'b0;
        end
      end
    end else begin
      if (ctl_go) begin
        case (ctl_op)
          OP_BR: if (tk != '0 && tk != cm && int'(csp) < DEPTH) begin
            st_nt[ctl_wid][SW'(csp)]  <= cm & ~tk;
            st_org[ctl_wid][SW'(csp)] <= cm;
            st_rpc[ctl_wid][SW'(csp)] <= ctl_rpc;
            st_ph[ctl_wid][SW'(csp)]  <= 1'b0;
            sp[ctl_wid]               <= csp + 1'b1;
            amask[ctl_wid]            <= tk;
          end
          OP_RECONV: if (csp != '0) begin
            if (!st_ph[ctl_wid][ctop]) begin
              amask[ctl_wid]       <= st_nt[ctl_wid][ctop];
              st_ph[ctl_wid][ctop] <= 1'b1;
            end else begin
              amask[ctl_wid] <= st_org[ctl_wid][ctop];
              sp[ctl_wid]    <= csp - 1'b1;
            end
          end
          OP_EXIT: resident[ctl_wid] <= 1'b0;
          default: ;
        endcase
      end
      if (launch && int'(launch_wid) < NWARP) begin
        resident[launch_wid] <= 1'b1;
        amask[launch_wid]    <= '1;
        sp[launch_wid]       <= '0;
      end
    end
  end

  wire boundary = !issue_valid || lane_grp == GW'(GRPS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issue_valid <= 1'b0;
      issue_wid   <= '0;
      lane_grp    <= '0;
      cur_mask    <= '0;
      issue_rpc   <= '0;
      last        <= WIDW'(NWARP - 1);
    end else if (boundary) begin
      issue_valid <= found;
      if (found) begin
        issue_wid <= sel;
        lane_grp  <= '0;
        cur_mask  <= amask[sel];
        last      <= sel;
        issue_rpc <= (sp[sel] != '0) ? st_rpc[sel][SW'(sp[sel] - 1'b1)] : '0;
      end
    end else begin
      lane_grp <= lane_grp + 1'b1;
    end
  end

  assign lane_en = issue_valid ? cur_mask[int'(lane_grp)*LANES +: LANES] : '0;

  AST_GRP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && lane_grp != GW'(GRPS - 1) |=>
      issue_valid && lane_grp == $past(lane_grp) + 1'b1 && issue_wid == $past(issue_wid)) // R2
    else $error("group sequence broken");
  AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && lane_grp == GW'(GRPS - 1) && (ready & resident) != '0 |=>
      issue_valid && lane_grp == '0) // R4
    else $error("bubble between instructions");
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> lane_en == '0) // R4
    else $error("enables while idle");
  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sp[ctl_wid]) <= DEPTH) // R10
    else $error("stack overflow");
  AST_FULL_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_op == OP_BR && int'(ctl_wid) < NWARP && int'(sp[ctl_wid]) == DEPTH &&
      !(launch && launch_wid == ctl_wid) |=>
      amask[$past(ctl_wid)] == $past(amask[ctl_wid])) // R10
    else $error("branch accepted on full stack");
endmodule

// File: tb/warp_issue_seq_tb.sv
module warp_issue_seq_tb;
  localparam int NWARP = 24;
  logic        clk = 0, rst_n = 0;
  logic [23:0] ready = '0;
  logic        launch = 0;
  logic [4:0]  launch_wid = '0, ctl_wid = '0;
  logic [1:0]  ctl_op = '0;
  logic [31:0] ctl_taken = '0;
  logic [7:0]  ctl_rpc = '0;
  logic        issue_valid;
  logic [4:0]  issue_wid;
  logic [1:0]  lane_grp;
  logic [7:0]  lane_en, issue_rpc;
  int checks = 0, fails = 0;
  bit done = 0;

  warp_issue_seq u_dut (.clk, .rst_n, .ready, .launch, .launch_wid, .ctl_op, .ctl_wid,
    .ctl_taken, .ctl_rpc, .issue_valid, .issue_wid, .lane_grp, .lane_en, .issue_rpc);

  always #10 clk = ~clk;

  task automatic step(); @(negedge clk); endtask

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_launch(int w);
    launch = 1; launch_wid = 5'(w); step(); launch = 0;
  endtask

  task automatic do_ctl(int op, int w, logic [31:0] t, logic [7:0] r);
    ctl_op = 2'(op); ctl_wid = 5'(w); ctl_taken = t; ctl_rpc = r; step(); ctl_op = 0;
  endtask

  task automatic issue_one(int w, logic [31:0] m, logic [7:0] r, string req);
    ready = 24'(1) << w; step(); ready = '0;
    for (int g = 0; g < 4; g++) begin
      check(issue_valid && issue_wid == 5'(w) && lane_grp == 2'(g), {req, "/R2 beat"},
            {issue_valid, issue_wid, lane_grp}, {1'b1, 5'(w), 2'(g)});
      check(lane_en == m[g*8 +: 8], {req, " lane_en"}, lane_en, m[g*8 +: 8]);
      if (g == 0) check(issue_rpc == r, {req, "/R7 rpc"}, issue_rpc, r);
      step();
    end
    check(!issue_valid && lane_en == 0, "R4 idle", issue_valid, 0);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    check(!issue_valid && lane_en == 0, "R1 reset idle", issue_valid, 0);
    ready = '1; step(); step();
    check(!issue_valid, "R1 nothing resident", issue_valid, 0);
    ready = '0;
    do_launch(0); do_launch(1); do_launch(2);
    step();
    ready = 24'b111; step();
    for (int k = 0; k < 24; k++) begin
      check(issue_valid && issue_wid == 5'((k / 4) % 3) && lane_grp == 2'(k % 4) &&
            lane_en == 8'hFF, "R3/R4 round robin", {issue_wid, lane_grp}, {5'((k / 4) % 3), 2'(k % 4)});
      if (k == 23) ready = '0;
      step();
    end
    check(!issue_valid, "R4 idle", issue_valid, 0);
    ready = 24'b10_0101; step();
    for (int k = 0; k < 16; k++) begin
      check(issue_valid && issue_wid == ((k / 4) % 2 == 0 ? 5'd0 : 5'd2) && lane_grp == 2'(k % 4),
            "R3/R5 skip", issue_wid, (k / 4) % 2 == 0 ? 0 : 2);
      if (k == 15) ready = '0;
      step();
    end
    check(!issue_valid, "R4 idle", issue_valid, 0);

    do_ctl(1, 0, 32'h00FF_00F0, 8'h21);
    issue_one(0, 32'h00FF_00F0, 8'h21, "R7/R11 taken");
    do_ctl(1, 0, 32'hFFFF_FFFF, 8'h33);
    issue_one(0, 32'h00FF_00F0, 8'h21, "R8 uniform taken");
    do_ctl(1, 0, 32'h0000_0000, 8'h34);
    issue_one(0, 32'h00FF_00F0, 8'h21, "R8 uniform not taken");
    do_ctl(2, 0, 0, 0);
    issue_one(0, 32'hFF00_FF0F, 8'h21, "R9 not-taken side");
    do_ctl(2, 0, 0, 0);
    issue_one(0, 32'hFFFF_FFFF, 8'h00, "R9 restore");
    do_ctl(2, 0, 0, 0);
    issue_one(0, 32'hFFFF_FFFF, 8'h00, "R9 empty pop");

    do_ctl(1, 2, 32'h0000_FFFF, 8'h11);
    do_ctl(1, 2, 32'h0000_00FF, 8'h12);
    do_ctl(1, 2, 32'h0000_000F, 8'h13);
    do_ctl(1, 2, 32'h0000_0003, 8'h14);
    do_ctl(1, 2, 32'h0000_0001, 8'h15);
    issue_one(2, 32'h0000_0003, 8'h14, "R10 full ignored");
    do_ctl(2, 2, 0, 0);
    issue_one(2, 32'h0000_000C, 8'h14, "R9 nested nt");
    do_ctl(2, 2, 0, 0);
    issue_one(2, 32'h0000_000F, 8'h13, "R9 nested restore");
    do_ctl(2, 2, 0, 0); do_ctl(2, 2, 0, 0);
    issue_one(2, 32'h0000_00FF, 8'h12, "R9 level2");
    do_ctl(2, 2, 0, 0); do_ctl(2, 2, 0, 0);
    do_ctl(2, 2, 0, 0);
    issue_one(2, 32'hFFFF_0000, 8'h11, "R9 level1 nt");
    do_ctl(2, 2, 0, 0);
    issue_one(2, 32'hFFFF_FFFF, 8'h00, "R9 outer restore");

    ready = 24'b10; step(); ready = '0;
    check(issue_valid && issue_wid == 1 && lane_grp == 0 && lane_en == 8'hFF, "R12 g0", lane_en, 8'hFF);
    step();
    check(lane_grp == 1 && lane_en == 8'hFF, "R12 g1", lane_en, 8'hFF);
    ctl_op = 1; ctl_wid = 1; ctl_taken = 32'h0000_00FF; ctl_rpc = 8'h40; step(); ctl_op = 0;
    check(lane_grp == 2 && lane_en == 8'hFF, "R12 g2 snapshot", lane_en, 8'hFF);
    step();
    check(lane_grp == 3 && lane_en == 8'hFF, "R12 g3 snapshot", lane_en, 8'hFF);
    step();
    issue_one(1, 32'h0000_00FF, 8'h40, "R12 next instr");

    launch = 1; launch_wid = 1; ctl_op = 2; ctl_wid = 1; step(); launch = 0; ctl_op = 0;
    issue_one(1, 32'hFFFF_FFFF, 8'h00, "R6 launch wins");
    do_ctl(1, 0, 32'h0F0F_0F0F, 8'h50);
    do_launch(0);
    issue_one(0, 32'hFFFF_FFFF, 8'h00, "R6 relaunch");

    do_ctl(3, 2, 0, 0);
    ready = 24'b100; step(); step();
    check(!issue_valid, "R5 exited warp", issue_valid, 0);
    ready = '0; step();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule